// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit Sequencer

This block sits behind a two-wire serial memory protocol engine and gathers the data bytes of one write transaction in an 8-entry page latch. The protocol engine loads the starting word address once, then strobes in each received data byte. Every byte goes to the latch slot picked by the low three address bits, and only those three bits advance, so a long burst wraps around inside one aligned 8-byte page. When a Stop ends the transaction, the block commits to a 128-byte array only the slots that were loaded. It does this through a simple one-byte-per-clock write port and holds a busy flag for a fixed, parameterised number of clocks. The protocol engine uses busy to withhold acknowledges while the cycle runs.

The cycle starts only on a Stop. A repeated Start discards the latched bytes. So does a Stop that arrives with nothing loaded or with the write-protect input high. In each of these cases no cycle starts and nothing reaches the array. The cycle length is given in system clocks so that the same logic serves both the full programming time and a short test setting.

Top module: `page_write_buf`

## Requirements
- R1: After reset, busy_o and mem_we_o are low and no latch slot counts as loaded.
- R2: Data byte k (counting from 0) after an address load of A lands at array address {A[6:3], (A[2:0]+k) mod 8}. Address bits 6..3 are identical for every write of one cycle.
- R3: When more than 8 bytes arrive before Stop, each slot keeps the last byte written to it. A cycle issues at most 8 array writes.
- R4: Only slots loaded during the transaction are written to the array. The other bytes of the page keep their previous contents.
- R5: A cycle starts only on a Stop, and only with at least one slot loaded. busy_o goes high in the clock after the one that samples stop_i.
- R6: busy_o stays high for exactly CYCLE_CLKS clocks. mem_we_o is high only while busy_o is high.
- R7: If wp_i is high when the Stop is sampled, no cycle starts, busy_o stays low, nothing is written and the latched bytes are dropped.
- R8: A repeated Start (rstart_i), or a Stop with no slot loaded, starts no cycle and clears every slot's loaded mark. A later Stop without new bytes therefore starts nothing.
- R9: While busy_o is high, address loads, data strobes and Stop/repeated-Start events are ignored.
- R10: A single-byte transaction uses the same path: one array write and a full CYCLE_CLKS busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load starting word address, clears loaded marks |
| start_addr_i | input | 7 | Starting word address |
| data_we_i | input | 1 | One received data byte is valid |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop condition ended the write transaction |
| rstart_i | input | 1 | Repeated Start ended the write transaction |
| wp_i | input | 1 | Write protect, high blocks all commits |
| busy_o | output | 1 | Timed write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 7 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The bound checker checks the following on every clock:
- busy rises only after a sampled Stop;
- a Stop with write protect, or a repeated Start, never raises busy;
- array writes never occur outside busy and stay inside one page;
- a counter shows that each busy period lasts exactly the programmed number of clocks.

Some behaviour only the bench's sweep over every start offset and burst length from zero to ten can show. This covers where each byte lands, wrap-around overwrite, the count of array writes, and that untouched bytes of a page are preserved. The bench's directed scenarios cover inputs being dropped during busy and marks being cleared after a discarded transaction.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // end-of-transaction decision
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_COMMIT  = 2'd1,
    EV_DISCARD = 2'd2
  } txn_ev_e;

  localparam int unsigned DEF_ADDR_W = 7;
  localparam int unsigned DEF_OFF_W  = 3;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NUM_ENT = 1 << OFF_W,
  localparam int unsigned PAGE_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clear_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [NUM_ENT-1:0] mask_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [OFF_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [NUM_ENT-1:0] mask_q;
  logic [DATA_W-1:0] ent_q [NUM_ENT];

  logic do_load, do_we;
  assign do_load = en_i & load_i;
  assign do_we   = en_i & we_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (do_load) begin
      ptr_q  <= load_addr_i[OFF_W-1:0];
      page_q <= load_addr_i[ADDR_W-1:OFF_W];
    end else if (do_we) begin
      ptr_q  <= ptr_q + 1'b1;  // low bits only: wraps inside page
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic hit;
    assign hit = do_we && (ptr_q == OFF_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= 1'b0;
        ent_q[g]  <= '0;
      end else begin
        if (clear_i || do_load) mask_q[g] <= 1'b0;
        else if (hit)           mask_q[g] <= 1'b1;
        if (hit) ent_q[g] <= wdata_i;
      end
    end
  end

  assign mask_o    = mask_q;
  assign page_o    = page_q;
  assign rd_data_o = ent_q[rd_idx_i];
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned CYCLE_CLKS = 1250000,
  localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic busy_q;

  assign done_o = busy_q && (cnt_q == CNT_W'(CYCLE_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pwb_scan.sv
module pwb_scan #(
  parameter int unsigned OFF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  output logic [OFF_W-1:0] idx_o,
  output logic             active_o
);
  logic [OFF_W:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (start_i && !busy_i)     idx_q <= '0;
    else if (busy_i && !idx_q[OFF_W]) idx_q <= idx_q + 1'b1;
  end

  assign idx_o    = idx_q[OFF_W-1:0];
  assign active_o = busy_i & ~idx_q[OFF_W];
endmodule

// File: rtl/page_write_buf.sv
module page_write_buf #(
  parameter int unsigned ADDR_W     = pwb_pkg::DEF_ADDR_W,
  parameter int unsigned OFF_W      = pwb_pkg::DEF_OFF_W,
  parameter int unsigned DATA_W     = pwb_pkg::DEF_DATA_W,
  parameter int unsigned CYCLE_CLKS = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              rstart_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  import pwb_pkg::*;

  localparam int unsigned NUM_ENT = 1 << OFF_W;
  localparam int unsigned PAGE_W  = ADDR_W - OFF_W;

  logic [NUM_ENT-1:0] mask;
  logic [PAGE_W-1:0]  page;
  logic [DATA_W-1:0]  rd_data;
  logic [OFF_W-1:0]   scan_idx;
  logic               scan_active;
  logic               busy, done;
  txn_ev_e            ev;

  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (rstart_i)                       ev = EV_DISCARD;
      else if (stop_i && |mask && !wp_i)  ev = EV_COMMIT;
      else if (stop_i)                    ev = EV_DISCARD;
    end
  end

  pwb_latch #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (~busy),
    .load_i      (addr_load_i),
    .load_addr_i (start_addr_i),
    .we_i        (data_we_i),
    .wdata_i     (data_i),
    .clear_i     ((ev == EV_DISCARD) | done),
    .rd_idx_i    (scan_idx),
    .mask_o      (mask),
    .page_o      (page),
    .rd_data_o   (rd_data)
  );

  pwb_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ev == EV_COMMIT),
    .busy_o  (busy),
    .done_o  (done)
  );

  pwb_scan #(.OFF_W(OFF_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ev == EV_COMMIT),
    .busy_i   (busy),
    .idx_o    (scan_idx),
    .active_o (scan_active)
  );

  assign busy_o     = busy;
  assign mem_we_o   = scan_active & mask[scan_idx];
  assign mem_addr_o = {page, scan_idx};
  assign mem_data_o = rd_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned CYCLE_CLKS = 1250000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              rstart_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int unsigned CW = $clog2(CYCLE_CLKS + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o);

  p_rise_needs_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  p_we_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  p_busy_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < CW'(CYCLE_CLKS));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == CW'(CYCLE_CLKS));

  p_wp_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  p_rstart_no_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstart_i && !busy_o) |=> !busy_o);

  p_same_page_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && busy_o && $past(busy_o) && $past(mem_we_o))
      |-> mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W]));
endmodule

bind page_write_buf pwb_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_pwb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .rstart_i   (rstart_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/page_write_buf_bench.sv
module page_write_buf_bench;
  localparam int CYC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [6:0] start_addr = '0;
  logic       data_we = 1'b0;
  logic [7:0] data = '0;
  logic       stop = 1'b0;
  logic       rstart = 1'b0;
  logic       wp = 1'b0;
  logic       busy, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_data;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [7:0] mirror  [128];
  logic [7:0] exp_mem [128];

  always #2 clk = ~clk;

  page_write_buf #(.CYCLE_CLKS(CYC)) u_page_write_buf (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(addr_load), .start_addr_i(start_addr),
    .data_we_i(data_we), .data_i(data), .stop_i(stop), .rstart_i(rstart), .wp_i(wp),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mirror[i] <= 8'h00;
      wr_cnt <= 0;
    end else if (mem_we) begin
      mirror[mem_addr] <= mem_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_addr(input int a);
    @(negedge clk); addr_load = 1'b1; start_addr = 7'(a);
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic send_byte(input int d);
    @(negedge clk); data_we = 1'b1; data = 8'(d);
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic end_txn(input logic is_rs, input logic wpv);
    @(negedge clk); wp = wpv; if (is_rs) rstart = 1'b1; else stop = 1'b1;
    @(negedge clk); rstart = 1'b0; stop = 1'b0;
  endtask

  // called right after end_txn: counts busy clocks
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 10*CYC) begin n++; @(negedge clk); end
    @(negedge clk); @(negedge clk);
  endtask

  function automatic int pat(input int off, input int n, input int k, input int v);
    return (off*37 + n*11 + k*29 + v*71 + 5) & 255;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int blen, w0, pg, commit;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 we", int'(mem_we), 0);
    end_txn(1'b0, 1'b0);
    busy_len(blen);
    check("R1 empty mask", blen, 0);

    // sweep: variant 0 stop, 1 stop with wp, 2 repeated start
    for (int v = 0; v < 3; v++)
      for (int off = 0; off < 8; off++)
        for (int n = 0; n <= 10; n++) begin
          pg = (off*11 + n + v*3) % 16;
          load_addr(pg*8 + off);
          for (int k = 0; k < n; k++) send_byte(pat(off, n, k, v));
          w0 = wr_cnt;
          end_txn(v == 2, v == 1);
          commit = (v == 0 && n > 0) ? 1 : 0;
          if (commit)
            for (int k = 0; k < n; k++) exp_mem[pg*8 + ((off+k) % 8)] = 8'(pat(off, n, k, v));
          busy_len(blen);
          if (v == 1)      check("R7 no cycle under wp", blen, 0);
          else if (v == 2) check("R8 no cycle on rstart", blen, 0);
          else if (n == 0) check("R8 empty stop", blen, 0);
          else if (n == 1) check("R10 single byte busy", blen, CYC);
          else             check("R5 R6 busy length", blen, CYC);
          check(n > 8 ? "R3 write count" : "R4 write count", wr_cnt - w0,
                commit ? (n > 8 ? 8 : n) : 0);
          for (int j = 0; j < 8; j++)
            check("R2 page content", int'(mirror[pg*8+j]), int'(exp_mem[pg*8+j]));
        end

    // R8: discarded bytes are not revived by a later stop
    load_addr(7'h45);
    send_byte(8'hAA); send_byte(8'hBB);
    end_txn(1'b1, 1'b0);
    busy_len(blen);
    w0 = wr_cnt;
    end_txn(1'b0, 1'b0);
    busy_len(blen);
    check("R8 marks cleared", blen, 0);
    check("R8 no writes", wr_cnt - w0, 0);

    // R9: inputs during busy are dropped
    load_addr(7'h12);
    send_byte(8'h3C);
    w0 = wr_cnt;
    end_txn(1'b0, 1'b0);
    exp_mem[7'h12] = 8'h3C;
    check("R5 busy after stop", int'(busy), 1);
    load_addr(7'h70);
    send_byte(8'h99); send_byte(8'h98);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    busy_len(blen);
    check("R9 busy length", blen, CYC - 8);
    check("R9 writes", wr_cnt - w0, 1);
    check("R9 target", int'(mirror[7'h12]), 8'h3C);
    check("R9 untouched", int'(mirror[7'h70]), int'(exp_mem[7'h70]));
    end_txn(1'b0, 1'b0);
    busy_len(blen);
    check("R9 no late cycle", blen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule